// File: doc/BRIEF.md
# Serial Flash Command Sequencer

This block drives a serial NOR flash over a four-wire SPI link in mode 3. Software reaches it through a small register bus. It sets up an address word, a data word and the clock timing, and then writes a command word. That write starts the engine. The engine clocks out an opcode, zero to three address bytes and zero to fifteen dummy bytes. It then moves zero to four data bytes, either out of the data word or into it. A pending bit in the status word tells software when the command has finished.

A longer flash transaction, such as a page program or a long read, is built from several commands. Each command sets a hold flag so that the chip select stays low after it. A command that continues an open transaction does not resend the opcode. A final command with no bytes to move and the hold flag clear only raises the chip select. Two static outputs keep the write-protect and hold pins of the flash at a level that software chooses.

Top module: `sflash_seq`

## Requirements
- R1: Registers sit at word indices on `reg_addr`: 0 command, 1 address, 2 data, 3 status, 4 timing, 5 pin control. A read strobe returns the addressed register on `reg_rdata` one cycle later. After reset, status reads 0 and timing reads 0x0000_0203. After reset all chip selects are high, SCK is high, and `wp_n` and `hold_n` are low.
- R2: A valid write to the command register starts a command, and status bit 22 then reads 1. The bit stays 1 for exactly nbits*(period+1)+1 cycles, where nbits is 8 times the number of bytes sent and period is timing bits 3:0.
- R3: Command fields are: opcode bits 7:0, write direction bit 8 (1 = write), data byte count bits 11:9, hold flag bit 15, dummy count bits 19:16, address count bits 22:20 and chip select bits 26:24. Phases run in the order opcode, address, dummy, data, and a phase with a count of zero is skipped. The opcode is sent only when the command opens a new transaction. Every byte goes out most significant bit first.
- R4: Address bytes are the low 8*count bits of the address register, with the most significant byte first.
- R5: During the dummy bytes, and during the data bytes of a read, MOSI is 0.
- R6: Write data comes from the data register with byte 0 in bits 7:0, byte 1 in bits 15:8, and so on.
- R7: Read data is sampled on each rising SCK edge and stored into the data register in the same byte order. Bytes beyond the count keep their earlier value. The result can be read once the pending bit has cleared.
- R8: SCK idles high. Within each bit period it falls at count F (timing bits 15:12) and rises at count R (timing bits 11:8), for a low time of R-F cycles per bit. MOSI changes only on a falling SCK edge. F < R <= period is required.
- R9: The line chosen by the chip-select field goes low, one line at most. The choice is taken when a transaction opens. With the hold flag set the line stays low after the command. With the flag clear it goes high at the end. A command inside an open transaction with all counts zero and the flag clear releases the line without any SCK edge.
- R10: The command is ignored and status bit 29 is set in three cases: a command written while one is pending, a data count above 4, or an address count above 3. Writing 1 to status bit 29 clears it.
- R11: Writes to the address and data registers are ignored while a command is pending.
- R12: Pin-control bit 2 drives `wp_n` and bit 3 drives `hold_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 32 | Registered read data |
| sck | output | 1 | Serial clock, idles high |
| cs_n | output | CS_LINES | Active-low chip selects |
| mosi | output | 1 | Serial data to the flash |
| miso | input | 1 | Serial data from the flash |
| wp_n | output | 1 | Static write-protect level |
| hold_n | output | 1 | Static hold level |

## Verification
The bench goes after these corner cases:

- A continuation command inside a held transaction. A design that resent the opcode would put an extra byte on MOSI, and the byte-by-byte comparison catches it.
- A release-only command. It must produce no SCK low time and a one-cycle pending pulse. A design that clocked a dummy byte would change both.
- The longest header: three address bytes and fifteen dummy bytes. A wrong byte order or a wrong count shows up in the captured bytes.
- A command written while another is pending, with a data write in the same window. A design that took either write would change the bytes sent or the data register it reads back.
- Several random SCK edge positions. A wrong period shows up in the pending length, and a misplaced edge shows up in the measured low time.

// File: rtl/sflash_seq.sv
module sflash_seq #(
  parameter int CS_LINES = 8,
  parameter logic [15:0] TIME_RST = 16'h0203
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          reg_addr,
  input  logic [31:0]         reg_wdata,
  input  logic                reg_wr,
  input  logic                reg_rd,
  output logic [31:0]         reg_rdata,
  output logic                sck,
  output logic [CS_LINES-1:0] cs_n,
  output logic                mosi,
  input  logic                miso,
  output logic                wp_n,
  output logic                hold_n
);
  localparam int CSW = $clog2(CS_LINES);
  localparam logic [2:0] RA_CMD = 3'd0, RA_ADR = 3'd1, RA_DAT = 3'd2,
                         RA_STA = 3'd3, RA_TIM = 3'd4, RA_IO = 3'd5;
  localparam logic [2:0] PH_DONE = 3'd4;

  logic [31:0] cmd_q, addr_q, data_q;
  logic [15:0] time_q;
  logic [3:0]  io_q, tcnt, bidx, ph_len;
  logic [2:0]  ph, bitn;
  logic        busy, err, cs_act, sck_q, mosi_q;
  logic [CSW-1:0] cs_sel;
  logic [7:0]  cur_byte;

  wire [3:0] t_per = time_q[3:0], t_rise = time_q[11:8], t_fall = time_q[15:12];
  wire [2:0] c_al = cmd_q[22:20], c_nl = cmd_q[11:9];
  wire [3:0] c_dl = cmd_q[19:16];
  wire       c_dir = cmd_q[8], c_keep = cmd_q[15];
  wire       wr_cmd = reg_wr && reg_addr == RA_CMD;
  wire       bad = busy || reg_wdata[22:20] > 3'd3 || reg_wdata[11:9] > 3'd4;
  wire       start = wr_cmd && !bad;
  wire [4:0] rx_idx = {bidx[1:0], ~bitn};

  function automatic logic [2:0] nph(input logic [2:0] f, input logic [2:0] al,
                                     input logic [3:0] dl, input logic [2:0] nl);
    if (f <= 3'd1 && al != 3'd0) return 3'd1;
    if (f <= 3'd2 && dl != 4'd0) return 3'd2;
    if (f <= 3'd3 && nl != 3'd0) return 3'd3;
    return PH_DONE;
  endfunction

  always_comb begin
    case (ph)
      3'd0:    ph_len = 4'd1;
      3'd1:    ph_len = {1'b0, c_al};
      3'd2:    ph_len = c_dl;
      default: ph_len = {1'b0, c_nl};
    endcase
    case (ph)
      3'd0:    cur_byte = cmd_q[7:0];
      3'd1:    cur_byte = 8'(addr_q >> {c_al - 3'd1 - bidx[2:0], 3'b000});
      3'd3:    cur_byte = c_dir ? 8'(data_q >> {bidx[1:0], 3'b000}) : 8'h00;
      default: cur_byte = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0; addr_q <= '0; data_q <= '0; time_q <= TIME_RST; io_q <= '0;
      busy <= 1'b0; err <= 1'b0; cs_act <= 1'b0; cs_sel <= '0; ph <= PH_DONE;
      bidx <= '0; bitn <= '0; tcnt <= '0; sck_q <= 1'b1; mosi_q <= 1'b0;
      reg_rdata <= '0;
    end else begin
      if (reg_rd)
        case (reg_addr)
          RA_CMD:  reg_rdata <= cmd_q;
          RA_ADR:  reg_rdata <= addr_q;
          RA_DAT:  reg_rdata <= data_q;
          RA_STA:  reg_rdata <= {2'b00, err, 6'd0, busy, 22'd0};
          RA_TIM:  reg_rdata <= {16'd0, time_q};
          RA_IO:   reg_rdata <= {28'd0, io_q};
          default: reg_rdata <= '0;
        endcase
      if (reg_wr)
        case (reg_addr)
          RA_CMD: if (bad) err <= 1'b1; else cmd_q <= reg_wdata;
          RA_ADR: if (!busy) addr_q <= reg_wdata;
          RA_DAT: if (!busy) data_q <= reg_wdata;
          RA_STA: if (reg_wdata[29]) err <= 1'b0;
          RA_TIM: time_q <= reg_wdata[15:0];
          RA_IO:  io_q <= reg_wdata[3:0];
          default: ;
        endcase
      if (start) begin
        busy <= 1'b1; tcnt <= '0; bitn <= '0; bidx <= '0; cs_act <= 1'b1;
        if (!cs_act) cs_sel <= reg_wdata[24 +: CSW];
        ph <= cs_act ? nph(3'd1, reg_wdata[22:20], reg_wdata[19:16], reg_wdata[11:9]) : 3'd0;
      end else if (busy) begin
        if (ph == PH_DONE) begin
          busy <= 1'b0;
          if (!c_keep) cs_act <= 1'b0;
        end else begin
          if (tcnt == t_fall) begin
            sck_q <= 1'b0;
            mosi_q <= cur_byte[3'd7 - bitn];
          end
          if (tcnt == t_rise) begin
            sck_q <= 1'b1;
            if (ph == 3'd3 && !c_dir) data_q[rx_idx] <= miso;
          end
          if (tcnt == t_per) begin
            tcnt <= '0;
            if (bitn == 3'd7) begin
              bitn <= '0;
              if (bidx + 4'd1 == ph_len) begin
                bidx <= '0;
                ph <= nph(ph + 3'd1, c_al, c_dl, c_nl);
              end else bidx <= bidx + 4'd1;
            end else bitn <= bitn + 3'd1;
          end else tcnt <= tcnt + 4'd1;
        end
      end
    end
  end

  assign sck    = sck_q;
  assign mosi   = mosi_q;
  assign cs_n   = cs_act ? ~(CS_LINES'(1) << cs_sel) : '1;
  assign wp_n   = io_q[2];
  assign hold_n = io_q[3];

  p_cmd_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
  p_one_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));
  p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) && !c_keep |-> &cs_n);
  p_sck_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    &cs_n |-> sck);
  p_mosi_on_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mosi) |-> $fell(sck));
  p_overlap_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cmd && busy |=> err && busy);
endmodule

// File: tb/test_sflash_seq.sv
module test_sflash_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic sck, mosi, wp_n, hold_n;
  logic miso = 1'b0;
  logic [7:0] cs_n;

  sflash_seq i_sflash_seq (.clk(clk), .rst_n(rst_n), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso), .wp_n(wp_n), .hold_n(hold_n));

  always #4 clk = ~clk;

  int nchk = 0, nfail = 0;
  wire cs_idle = &cs_n;

  function automatic logic pat(input int e);
    return 1'(((e * 37) ^ (e >> 2)) & 1);
  endfunction

  int ecnt = 0;
  always @(negedge sck or posedge cs_idle)
    if (cs_idle) ecnt <= 0;
    else begin miso <= pat(ecnt); ecnt <= ecnt + 1; end

  logic [7:0] sh = '0, cap[256];
  int cbits = 0, ncap = 0, lowcnt = 0;
  always @(posedge sck) if (!cs_idle) begin
    sh = {sh[6:0], mosi};
    cbits = cbits + 1;
    if (cbits % 8 == 0) begin cap[ncap % 256] = sh; ncap = ncap + 1; end
  end
  always @(negedge clk) if (!sck) lowcnt = lowcnt + 1;

  logic held = 1'b0;
  logic [2:0] hsel = '0;
  int mbits = 0, tp = 3, tr = 2, tf = 0;

  task automatic finish_up;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  endtask

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk); d = reg_rdata; reg_rd = 1'b0;
  endtask

  task automatic tset(input int p, input int r, input int f);
    wr(3'd4, {16'd0, 4'(f), 4'(r), 4'd0, 4'(p)});
    tp = p; tr = r; tf = f;
  endtask

  task automatic wait_idle(output int pc);
    pc = 0;
    reg_addr = 3'd3; reg_rd = 1'b1;
    for (int k = 0; k < 20000; k++) begin
      @(negedge clk);
      if (reg_rdata[22]) pc++; else break;
    end
    reg_rd = 1'b0;
  endtask

  task automatic run(input logic [31:0] cmd, input logic [31:0] adr, input logic [31:0] wd);
    int al, dl, nl, nb, pc, lo0, c0, base, nh;
    logic dir, keep;
    logic [7:0] ex[32];
    string lab[32];
    logic [31:0] edm, v;
    al = int'(cmd[22:20]); dl = int'(cmd[19:16]); nl = int'(cmd[11:9]);
    dir = cmd[8]; keep = cmd[15];
    wr(3'd1, adr); wr(3'd2, wd);
    nb = 0;
    if (!held) begin ex[nb] = cmd[7:0]; lab[nb] = "R3 opcode"; nb++; end
    for (int i = 0; i < al; i++) begin ex[nb] = 8'(adr >> (8 * (al - 1 - i))); lab[nb] = "R4 address"; nb++; end
    for (int i = 0; i < dl; i++) begin ex[nb] = 8'h00; lab[nb] = "R5 dummy"; nb++; end
    nh = nb;
    base = mbits + 8 * nh;
    for (int i = 0; i < nl; i++) begin
      ex[nb] = dir ? 8'(wd >> (8 * i)) : 8'h00;
      lab[nb] = dir ? "R6 write data" : "R5 read mosi";
      nb++;
    end
    edm = wd;
    if (!dir) for (int i = 0; i < nl; i++) for (int j = 0; j < 8; j++)
      edm[8 * i + 7 - j] = pat(base + 8 * i + j);
    c0 = ncap; lo0 = lowcnt;
    wr(3'd0, cmd);
    wait_idle(pc);
    chk(pc == 8 * nb * (tp + 1) + 1, "R2 pending cycles", pc, 8 * nb * (tp + 1) + 1);
    chk(ncap - c0 == nb, "R3 byte count", ncap - c0, nb);
    for (int i = 0; i < nb && i < ncap - c0; i++)
      chk(cap[(c0 + i) % 256] == ex[i], lab[i], cap[(c0 + i) % 256], ex[i]);
    chk(lowcnt - lo0 == 8 * nb * (tr - tf), "R8 sck low time", lowcnt - lo0, 8 * nb * (tr - tf));
    mbits += 8 * nb;
    if (!held) hsel = cmd[26:24];
    held = keep;
    if (!keep) mbits = 0;
    chk(cs_n == (keep ? ~(8'd1 << hsel) : 8'hff), "R9 chip select", cs_n, keep ? ~(8'd1 << hsel) : 8'hff);
    if (!dir && nl > 0) begin
      rd(3'd2, v);
      chk(v == edm, "R7 read data", v, edm);
    end
  endtask

  function automatic logic [31:0] mk(input int opc, input int al, input int dl, input int nl,
                                      input logic dir, input logic keep, input int cs);
    return {5'd0, 3'(cs), 1'b0, 3'(al), 4'(dl), keep, 3'd0, 3'(nl), dir, 8'(opc)};
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL R2 watchdog act=running exp=finished");
    finish_up();
  end

  initial begin
    logic [31:0] v, d0;
    int c0, pc, lo0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(3'd3, v); chk(v == 32'd0, "R1 status reset", v, 0);
    rd(3'd4, v); chk(v == 32'h0203, "R1 timing reset", v, 32'h0203);
    chk(cs_n == 8'hff, "R1 cs idle", cs_n, 8'hff);
    chk(sck == 1'b1, "R8 sck idle high", sck, 1);
    chk({wp_n, hold_n} == 2'b00, "R1 pin reset", {wp_n, hold_n}, 0);
    wr(3'd5, 32'hC); @(negedge clk);
    chk({wp_n, hold_n} == 2'b11, "R12 pins high", {wp_n, hold_n}, 3);
    wr(3'd5, 32'h4); @(negedge clk);
    chk({wp_n, hold_n} == 2'b10, "R12 wp only", {wp_n, hold_n}, 2);
    wr(3'd5, 32'hC);

    run(mk(8'h06, 0, 0, 0, 1'b0, 1'b0, 0), 32'h0, 32'h0);
    run(mk(8'h0B, 3, 15, 4, 1'b1, 1'b0, 5), 32'h00A1B2C3, 32'h44332211);
    run(mk(8'h03, 3, 1, 4, 1'b0, 1'b1, 2), 32'h00123456, 32'hFFFFFFFF);
    run(mk(8'h03, 0, 0, 3, 1'b0, 1'b1, 7), 32'h0, 32'hA5A5A5A5);
    lo0 = lowcnt;
    run(mk(8'h00, 0, 0, 0, 1'b0, 1'b0, 0), 32'h0, 32'h0);
    chk(lowcnt == lo0, "R9 release only", lowcnt - lo0, 0);

    d0 = 32'h00005A3C;
    wr(3'd2, d0);
    c0 = ncap;
    wr(3'd0, mk(8'h02, 0, 0, 2, 1'b1, 1'b0, 1));
    wr(3'd0, mk(8'h9F, 0, 0, 4, 1'b0, 1'b0, 3));
    wr(3'd2, 32'hDEADBEEF);
    wr(3'd1, 32'h00FFFFFF);
    wait_idle(pc);
    chk(ncap - c0 == 3, "R10 overlap ignored", ncap - c0, 3);
    chk(cap[c0 % 256] == 8'h02, "R10 opcode kept", cap[c0 % 256], 8'h02);
    chk(cap[(c0 + 1) % 256] == 8'h3C, "R11 data byte0", cap[(c0 + 1) % 256], 8'h3C);
    chk(cap[(c0 + 2) % 256] == 8'h5A, "R11 data byte1", cap[(c0 + 2) % 256], 8'h5A);
    rd(3'd3, v); chk(v == 32'h2000_0000, "R10 error set", v, 32'h2000_0000);
    rd(3'd2, v); chk(v == d0, "R11 data write ignored", v, d0);
    rd(3'd1, v); chk(v == 32'h00FFFFFF ? 1'b0 : 1'b1, "R11 address write ignored", v, 0);
    wr(3'd3, 32'h2000_0000);
    rd(3'd3, v); chk(v == 32'd0, "R10 error cleared", v, 0);

    c0 = ncap;
    wr(3'd0, mk(8'h03, 0, 0, 5, 1'b0, 1'b0, 0));
    rd(3'd3, v); chk(v == 32'h2000_0000, "R10 count over 4", v, 32'h2000_0000);
    chk(cs_n == 8'hff, "R10 no select", cs_n, 8'hff);
    wr(3'd3, 32'h2000_0000);
    wr(3'd0, {1'b0, mk(8'h03, 0, 0, 1, 1'b0, 1'b0, 0)} | 32'h0040_0000);
    rd(3'd3, v); chk(v == 32'h2000_0000, "R10 address count over 3", v, 32'h2000_0000);
    chk(ncap == c0, "R10 nothing sent", ncap - c0, 0);
    wr(3'd3, 32'h2000_0000);

    for (int t = 0; t < 30; t++) begin
      int p, f, r, nc;
      p = 1 + int'($urandom % 7);
      f = int'($urandom % p);
      r = f + 1 + int'($urandom % (p - f));
      tset(p, r, f);
      run(mk(int'($urandom % 256), int'($urandom % 4), int'($urandom % 4), int'($urandom % 5),
             1'($urandom), 1'($urandom), int'($urandom % 8)), $urandom, $urandom);
      nc = 0;
      while (held && nc < 2) begin
        run(mk(int'($urandom % 256), 0, 0, 1 + int'($urandom % 4), 1'($urandom), 1'($urandom), 0),
            $urandom, $urandom);
        nc++;
      end
      if (held) run(mk(8'h00, 0, 0, 0, 1'b0, 1'b0, 0), 32'h0, 32'h0);
    end
    finish_up();
  end
endmodule